// File: doc/BRIEF.md
# Two-wide register renamer with free list

This block sits at decode in an out-of-order core built around one unified physical register file. Each cycle it takes up to two decoded instructions, an older lane A and a younger lane B. It turns their architectural source specifiers into physical tags and gives each register-writing instruction a fresh physical destination taken from a free-register bitmap. No register data passes through the block. For every destination it also reads out the physical register that the destination replaces, which is the old tag. That tag travels with the instruction down the pipeline.

The old tag has two later uses. When the instruction commits, the pipeline returns the old tag through the commit port and that register becomes free again. On a trap or mispredict, the pipeline instead walks the in-flight instructions back one per cycle, youngest first. Each undo writes the old tag back into the map entry of its architectural destination and frees the tag that the instruction had been given. Architectural register 0 is never renamed and always reads physical register 0.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i, and only the physical registers numbered NARCH and above are free.
- R2: A source tag is the current map entry of its architectural register. Source 0 always yields tag 0.
- R3: A lane requests a destination when it is valid, its write enable is set and its destination is not 0. An accepted request gets the lowest-numbered free register. When both lanes request, lane B gets the second-lowest. An allocated register stops being free.
- R4: The old tag of a requesting lane is the map entry of its destination before this cycle's update. After acceptance, that map entry holds the new tag. If both lanes write the same register, lane B's tag is the one kept.
- R5: Lane B sees lane A's result in the same cycle. A lane B source equal to lane A's requested destination takes lane A's new tag. If lane B writes the same destination, its old tag is lane A's new tag.
- R6: A lane that does not request a destination outputs 0 for both its new and old tags, allocates nothing and leaves the map unchanged.
- R7: ren_ready is 1 exactly when no undo is presented and the free count is at least the number of requests. While it is 0, no lane is accepted and neither the map nor the free set is changed by rename.
- R8: A commit with a nonzero tag makes that register free in the next cycle, so it can be allocated again.
- R9: An undo writes its old tag into the map entry of its destination (destination 0 is left alone) and frees its new tag (tag 0 is never freed). Rename is held off in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Lane A (older) instruction present |
| a_wen | input | 1 | Lane A writes a register |
| a_rd | input | AW | Lane A architectural destination |
| a_rs1 | input | AW | Lane A architectural source 1 |
| a_rs2 | input | AW | Lane A architectural source 2 |
| b_valid | input | 1 | Lane B (younger) instruction present |
| b_wen | input | 1 | Lane B writes a register |
| b_rd | input | AW | Lane B architectural destination |
| b_rs1 | input | AW | Lane B architectural source 1 |
| b_rs2 | input | AW | Lane B architectural source 2 |
| cm_valid | input | 1 | Commit returns a register |
| cm_tag | input | PW | Old tag of the committing instruction |
| ud_valid | input | 1 | Undo one renamed instruction |
| ud_rd | input | AW | Architectural destination being undone |
| ud_pd | input | PW | New tag of the undone instruction |
| ud_old | input | PW | Old tag to restore |
| ren_ready | output | 1 | Both lanes accepted this cycle |
| a_ps1 | output | PW | Lane A physical source 1 |
| a_ps2 | output | PW | Lane A physical source 2 |
| a_pd | output | PW | Lane A new destination tag |
| a_old | output | PW | Lane A old destination tag |
| b_ps1 | output | PW | Lane B physical source 1 |
| b_ps2 | output | PW | Lane B physical source 2 |
| b_pd | output | PW | Lane B new destination tag |
| b_old | output | PW | Lane B old destination tag |

## Verification
The sweep first reads every architectural register straight after reset to confirm the identity map. It then runs a long pseudo-random mix of rename pairs, commits of the oldest in-flight instruction and undos of the youngest, compared every cycle against an arithmetic model in the bench. The lane patterns are chosen to separate cases. Lane B reading or writing lane A's destination shows whether the in-group forwarding works. Destination 0 or a cleared write enable shows that no register is allocated. Heavy allocation drives the free set empty, which shows that a stall freezes state. Directed steps then confirm that a committed tag is the next one allocated, and that an undo restores the source mapping and holds rename off.

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NARCH = 8,
  parameter int NPHYS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_valid,
  input  logic                     a_wen,
  input  logic [$clog2(NARCH)-1:0] a_rd,
  input  logic [$clog2(NARCH)-1:0] a_rs1,
  input  logic [$clog2(NARCH)-1:0] a_rs2,
  input  logic                     b_valid,
  input  logic                     b_wen,
  input  logic [$clog2(NARCH)-1:0] b_rd,
  input  logic [$clog2(NARCH)-1:0] b_rs1,
  input  logic [$clog2(NARCH)-1:0] b_rs2,
  input  logic                     cm_valid,
  input  logic [$clog2(NPHYS)-1:0] cm_tag,
  input  logic                     ud_valid,
  input  logic [$clog2(NARCH)-1:0] ud_rd,
  input  logic [$clog2(NPHYS)-1:0] ud_pd,
  input  logic [$clog2(NPHYS)-1:0] ud_old,
  output logic                     ren_ready,
  output logic [$clog2(NPHYS)-1:0] a_ps1,
  output logic [$clog2(NPHYS)-1:0] a_ps2,
  output logic [$clog2(NPHYS)-1:0] a_pd,
  output logic [$clog2(NPHYS)-1:0] a_old,
  output logic [$clog2(NPHYS)-1:0] b_ps1,
  output logic [$clog2(NPHYS)-1:0] b_ps2,
  output logic [$clog2(NPHYS)-1:0] b_pd,
  output logic [$clog2(NPHYS)-1:0] b_old
);
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);

  logic [PW-1:0]    map_q [NARCH];
  logic [NPHYS-1:0] free_q;
  logic [PW-1:0]    f0, f1;
  logic [PW:0]      nfree, need;
  logic [NPHYS-1:0] alloc, rel;

  wire a_req = a_valid & a_wen & (a_rd != '0);
  wire b_req = b_valid & b_wen & (b_rd != '0);
  wire a_hit1 = a_req & (b_rs1 == a_rd);
  wire a_hit2 = a_req & (b_rs2 == a_rd);
  wire a_hitd = a_req & (b_rd == a_rd);

  always_comb begin
    f0 = '0;
    f1 = '0;
    for (int i = NPHYS - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        f1 = f0;
        f0 = PW'(i);
      end
    end
  end

  assign nfree = (PW+1)'($countones(free_q));
  assign need  = (PW+1)'(a_req) + (PW+1)'(b_req);
  assign ren_ready = !ud_valid && (nfree >= need);

  assign a_ps1 = map_q[a_rs1];
  assign a_ps2 = map_q[a_rs2];
  assign a_pd  = a_req ? f0 : '0;
  assign a_old = a_req ? map_q[a_rd] : '0;
  assign b_ps1 = a_hit1 ? a_pd : map_q[b_rs1];
  assign b_ps2 = a_hit2 ? a_pd : map_q[b_rs2];
  assign b_pd  = b_req ? (a_req ? f1 : f0) : '0;
  assign b_old = b_req ? (a_hitd ? a_pd : map_q[b_rd]) : '0;

  always_comb begin
    alloc = '0;
    rel   = '0;
    if (ren_ready && a_req) alloc[a_pd] = 1'b1;
    if (ren_ready && b_req) alloc[b_pd] = 1'b1;
    if (cm_valid && cm_tag != '0) rel[cm_tag] = 1'b1;
    if (ud_valid && ud_pd != '0) rel[ud_pd] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < NPHYS; i++) free_q[i] <= (i >= NARCH);
    end else begin
      free_q <= (free_q & ~alloc) | rel;
      if (ren_ready && a_req) map_q[a_rd] <= a_pd;
      if (ren_ready && b_req) map_q[b_rd] <= b_pd;
      if (ud_valid && ud_rd != '0) map_q[ud_rd] <= ud_old;
    end
  end

  // R2
  zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_q[0] == '0);
  // R3
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ready && a_req) |-> free_q[a_pd]);
  // R3
  distinct_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ready && a_req && b_req) |-> (a_pd != b_pd));
  // R4
  map_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ready && a_req && !(b_req && a_hitd)) |=> map_q[$past(a_rd)] == $past(a_pd));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_ready && !cm_valid && !ud_valid) |=> nfree == $past(nfree));
  // R8
  commit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_tag != '0) |=> free_q[$past(cm_tag)]);
  // R9
  undo_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_valid && ud_pd != '0) |=> free_q[$past(ud_pd)]);
endmodule

// File: tb/tb_rename_unit.sv
module tb_rename_unit;
  localparam int NA = 8;
  localparam int NP = 16;

  logic clk = 0, rst_n = 0;
  logic a_valid, a_wen, b_valid, b_wen, cm_valid, ud_valid, ren_ready;
  logic [2:0] a_rd, a_rs1, a_rs2, b_rd, b_rs1, b_rs2, ud_rd;
  logic [3:0] cm_tag, ud_pd, ud_old;
  logic [3:0] a_ps1, a_ps2, a_pd, a_old, b_ps1, b_ps2, b_pd, b_old;

  rename_unit #(.NARCH(NA), .NPHYS(NP)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int m_map [NA];
  bit m_free [NP];
  int q_rd[$], q_pd[$], q_old[$];
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd(int n);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 8) % n);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_valid = 0; a_wen = 0; a_rd = 0; a_rs1 = 0; a_rs2 = 0;
    b_valid = 0; b_wen = 0; b_rd = 0; b_rs1 = 0; b_rs2 = 0;
    cm_valid = 0; cm_tag = 0; ud_valid = 0; ud_rd = 0; ud_pd = 0; ud_old = 0;
  endtask

  task automatic step();
    bit ar, br, rdy;
    int nf, need, e0, e1, ea_pd, eb_pd, ea_old, eb_old;
    #1;
    ar = a_valid && a_wen && a_rd != 0;
    br = b_valid && b_wen && b_rd != 0;
    nf = 0; e0 = 0; e1 = 0;
    for (int i = NP - 1; i >= 0; i--) if (m_free[i]) begin nf++; e1 = e0; e0 = i; end
    need = int'(ar) + int'(br);
    rdy = !ud_valid && nf >= need;
    ea_pd = ar ? e0 : 0;
    eb_pd = br ? (ar ? e1 : e0) : 0;
    ea_old = ar ? m_map[a_rd] : 0;
    eb_old = br ? ((ar && b_rd == a_rd) ? ea_pd : m_map[b_rd]) : 0;
    chk(ud_valid ? "R9 ready during undo" : "R7 ren_ready", int'(ren_ready), int'(rdy));
    chk("R2 a_ps1", a_ps1, m_map[a_rs1]);
    chk("R2 a_ps2", a_ps2, m_map[a_rs2]);
    chk("R5 b_ps1", b_ps1, (ar && b_rs1 == a_rd) ? ea_pd : m_map[b_rs1]);
    chk("R5 b_ps2", b_ps2, (ar && b_rs2 == a_rd) ? ea_pd : m_map[b_rs2]);
    chk(ar ? "R3 a_pd" : "R6 a_pd", a_pd, ea_pd);
    chk(br ? "R3 b_pd" : "R6 b_pd", b_pd, eb_pd);
    chk(ar ? "R4 a_old" : "R6 a_old", a_old, ea_old);
    chk(br ? "R5 b_old" : "R6 b_old", b_old, eb_old);
    @(posedge clk);
    if (rdy && ar) begin
      q_rd.push_back(a_rd); q_pd.push_back(ea_pd); q_old.push_back(ea_old);
      m_free[ea_pd] = 0; m_map[a_rd] = ea_pd;
    end
    if (rdy && br) begin
      q_rd.push_back(b_rd); q_pd.push_back(eb_pd); q_old.push_back(eb_old);
      m_free[eb_pd] = 0; m_map[b_rd] = eb_pd;
    end
    if (cm_valid && cm_tag != 0) m_free[cm_tag] = 1;
    if (ud_valid) begin
      if (ud_rd != 0) m_map[ud_rd] = ud_old;
      if (ud_pd != 0) m_free[ud_pd] = 1;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_commit();
    cm_valid = 1; cm_tag = 4'(q_old.pop_front());
    void'(q_rd.pop_front()); void'(q_pd.pop_front());
  endtask

  task automatic do_undo();
    ud_valid = 1; ud_rd = 3'(q_rd.pop_back());
    ud_pd = 4'(q_pd.pop_back()); ud_old = 4'(q_old.pop_back());
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ctag, urd, uold;
    idle();
    for (int i = 0; i < NA; i++) m_map[i] = i;
    for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NA; i++) begin
      a_rs1 = 3'(i); b_rs2 = 3'(i);
      #1;
      chk("R1 reset map a_ps1", a_ps1, i);
      chk("R1 reset map b_ps2", b_ps2, i);
      chk("R1 ready at reset", int'(ren_ready), 1);
      @(negedge clk);
    end
    idle();
    a_valid = 1; a_wen = 1; a_rd = 3;
    #1 chk("R1 first free register", a_pd, NA);
    step();

    for (int n = 0; n < 4000; n++) begin
      int op = rnd(10);
      if (op < 2 && q_rd.size() > 0) do_commit();
      if (op == 2 && q_rd.size() > 0) do_undo();
      else begin
        a_valid = rnd(4) != 0; a_wen = rnd(4) != 0; a_rd = 3'(rnd(NA));
        a_rs1 = 3'(rnd(NA)); a_rs2 = 3'(rnd(NA));
        b_valid = rnd(4) != 0; b_wen = rnd(4) != 0; b_rd = 3'(rnd(NA));
        b_rs1 = (rnd(3) == 0) ? a_rd : 3'(rnd(NA));
        b_rs2 = (rnd(3) == 0) ? a_rd : 3'(rnd(NA));
        if (rnd(3) == 0) b_rd = a_rd;
      end
      step();
    end

    while (q_rd.size() > 0) begin do_commit(); step(); end
    for (int k = 0; k < 20; k++) begin
      a_valid = 1; a_wen = 1; a_rd = 3'(1 + k % 7);
      step();
    end
    a_valid = 1; a_wen = 1; a_rd = 5;
    #1 chk("R7 stall when free set empty", int'(ren_ready), 0);
    step();
    ctag = q_old[0];
    do_commit(); step();
    a_valid = 1; a_wen = 1; a_rd = 2;
    #1 chk("R8 committed tag reallocated", a_pd, ctag);
    step();
    urd = q_rd[q_rd.size() - 1];
    uold = q_old[q_old.size() - 1];
    do_undo(); step();
    a_rs1 = 3'(urd);
    #1 chk("R9 undo restores mapping", a_ps1, uold);
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule